// File: doc/BRIEF.md
# Addressed Two-Wire Serial Register Receiver

This block takes write packets from a slow two-wire link made of a clock line and a data line, and turns each packet addressed to it into a single write into a local byte register bank. Both link lines are brought into the system clock domain through a two-flop synchroniser. A rising edge of the synchronised link clock marks one data bit. Every packet has exactly 22 bits. The first field is an 8-bit device address. The second is a 6-bit register index. The third is an 8-bit value. Each field arrives least significant bit first.

The link has no start or stop marker. The receiver finds frame boundaries only by counting link clock rising edges since reset. When the device address in a frame equals the `dev_addr` input, the block emits a registered one-cycle write, and the bank stores the value. A frame for another device is counted and then dropped.

The bank holds four groups of `NUM_CH` bytes: setpoints, offset low bytes, offset high bytes and gains. The whole bank is presented on a flat output bus. The write output is a valid-only stream with no ready: the serial link cannot be stalled, so downstream logic must accept every strobe in the cycle it appears. There is no back-pressure.

Top module: `twowire_reg_rx`

## Requirements
- R1: A data bit is taken only at a rising edge of the synchronised link clock. Changes on `link_dat` while `link_clk` is low have no effect on the decoded frame.
- R2: A frame is 22 link rising edges long. The first 8 bits are the device address, the next 6 bits are the register index, and the last 8 bits are the value. Each field is sent least significant bit first.
- R3: When the frame address equals `dev_addr`, `wr_valid` is high for exactly one cycle. In that cycle `wr_addr` = {2'b00, index} and `wr_data` = value. The strobe appears at the third rising system clock edge after the final link rising edge is applied at the inputs.
- R4: When the frame address differs from `dev_addr`, `wr_valid` stays low and no bank byte changes.
- R5: `frame_done` is high for one cycle at the end of every frame, matched or not, in the same cycle as any `wr_valid` of that frame.
- R6: After the 22nd bit the receiver is back at the address field, so back-to-back frames decode with no gap or marker.
- R7: A strobe with `wr_addr` below 4*`NUM_CH` updates bank byte `wr_addr` on the next clock. Byte i sits at `reg_file[8*i+7:8*i]`. A strobe with index 4*`NUM_CH` to 63 changes no byte.
- R8: Reset values of the bank are as follows. Bytes 0 to `NUM_CH`-1 (setpoints) and 3*`NUM_CH` to 4*`NUM_CH`-1 (gains) reset to 8'h80. The offset bytes reset to 8'h00.
- R9: Synchronous reset `rst` (active high) drives `wr_valid` and `frame_done` low, clears the shift register and returns the receiver to the start of the address field, even in the middle of a frame.
- R10: The device address compared against is the live `dev_addr` input at the end of the frame. Changing it changes which frames are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| link_clk | input | 1 | Serial link clock, asynchronous |
| link_dat | input | 1 | Serial link data, stable before link_clk rises |
| dev_addr | input | 8 | Device address this receiver answers to |
| wr_valid | output | 1 | One-cycle write strobe (no ready) |
| wr_addr | output | 8 | Register index of the write, upper two bits zero |
| wr_data | output | 8 | Value of the write |
| frame_done | output | 1 | One-cycle pulse at the end of every frame |
| reg_file | output | 8*4*NUM_CH | Flat view of the register bank, byte i at bits 8i+7:8i |

## Verification
After the bench raises the link clock for the last bit of a frame, the path runs through two synchroniser flops and then the output register. `wr_valid` and `frame_done` are therefore due on the third system clock edge. The bench samples on the falling edge and records the falling-edge number within the high phase at which each pulse is seen. It requires that number to be exactly 3, and requires exactly one pulse per frame. The bank byte follows one edge later. The bank is compared against the bench model only after the link clock has gone low again, several cycles after the strobe.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    FLD_ADDR = 2'd0,
    FLD_SUB  = 2'd1,
    FLD_DATA = 2'd2
  } fld_e;

  localparam int BYTE_W = 8;

  // Reset value of bank byte idx: groups 0 (setpoints) and 3 (gains) mid-scale.
  function automatic logic [BYTE_W-1:0] reg_reset_val(input int idx, input int nch);
    int grp;
    grp = idx / nch;
    return (grp == 0 || grp == 3) ? 8'h80 : 8'h00;
  endfunction

endpackage

// File: rtl/srx_link_sync.sv
module srx_link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic link_clk,
  input  logic link_dat,
  output logic bit_stb,
  output logic bit_val
);

  logic [STAGES-1:0] clk_ff;
  logic [STAGES-1:0] dat_ff;
  logic              clk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_ff   <= '0;
      dat_ff   <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_ff   <= {clk_ff[STAGES-2:0], link_clk};
      dat_ff   <= {dat_ff[STAGES-2:0], link_dat};
      clk_prev <= clk_ff[STAGES-1];
    end
  end

  assign bit_stb = clk_ff[STAGES-1] & ~clk_prev;
  assign bit_val = dat_ff[STAGES-1];

endmodule

// File: rtl/srx_deframer.sv
module srx_deframer
  import srx_pkg::*;
#(
  parameter int SUB_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic [BYTE_W-1:0] dev_addr,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              frame_done
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int PAD_W = BYTE_W - SUB_W;

  fld_e              fld_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] sh_n;
  logic [BYTE_W-1:0] addr_q;
  logic [BYTE_W-1:0] sub_q;

  assign sh_n = {bit_val, sh_q[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q      <= FLD_ADDR;
      cnt_q      <= CNT_W'(BYTE_W);
      sh_q       <= '0;
      addr_q     <= '0;
      sub_q      <= '0;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      frame_done <= 1'b0;
    end else begin
      wr_valid   <= 1'b0;
      frame_done <= 1'b0;
      if (bit_stb) begin
        sh_q <= sh_n;
        if (cnt_q == CNT_W'(1)) begin
          unique case (fld_q)
            FLD_ADDR: begin
              addr_q <= sh_n;
              fld_q  <= FLD_SUB;
              cnt_q  <= CNT_W'(SUB_W);
            end
            FLD_SUB: begin
              sub_q <= sh_n >> PAD_W;
              fld_q <= FLD_DATA;
              cnt_q <= CNT_W'(BYTE_W);
            end
            default: begin
              fld_q      <= FLD_ADDR;
              cnt_q      <= CNT_W'(BYTE_W);
              frame_done <= 1'b1;
              if (addr_q == dev_addr) begin
                wr_valid <= 1'b1;
                wr_addr  <= sub_q;
                wr_data  <= sh_n;
              end
            end
          endcase
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/srx_reg_bank.sv
module srx_reg_bank
  import srx_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_REGS = 4 * NUM_CH
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_valid,
  input  logic [BYTE_W-1:0]          wr_addr,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [NUM_REGS*BYTE_W-1:0] reg_file
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [BYTE_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst)
        val_q <= reg_reset_val(i, NUM_CH);
      else if (wr_valid && wr_addr == BYTE_W'(i))
        val_q <= wr_data;
    end
    assign reg_file[BYTE_W*i +: BYTE_W] = val_q;
  end

endmodule

// File: rtl/twowire_reg_rx.sv
module twowire_reg_rx
  import srx_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SUB_W       = 6,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_REGS   = 4 * NUM_CH
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       link_clk,
  input  logic                       link_dat,
  input  logic [7:0]                 dev_addr,
  output logic                       wr_valid,
  output logic [7:0]                 wr_addr,
  output logic [7:0]                 wr_data,
  output logic                       frame_done,
  output logic [NUM_REGS*8-1:0]      reg_file
);

  logic bit_stb;
  logic bit_val;

  srx_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .link_clk (link_clk),
    .link_dat (link_dat),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val)
  );

  srx_deframer #(.SUB_W(SUB_W)) u_defr (
    .clk        (clk),
    .rst        (rst),
    .bit_stb    (bit_stb),
    .bit_val    (bit_val),
    .dev_addr   (dev_addr),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .frame_done (frame_done)
  );

  srx_reg_bank #(.NUM_CH(NUM_CH), .NUM_REGS(NUM_REGS)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .reg_file (reg_file)
  );

endmodule

// File: rtl/twowire_reg_rx_chk.sv
module twowire_reg_rx_chk #(
  parameter int NUM_REGS = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_valid,
  input logic [7:0]            wr_addr,
  input logic                  frame_done,
  input logic [NUM_REGS*8-1:0] reg_file
);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid); // R3

  AST_STROBE_IN_FRAME_END: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> frame_done); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R5

  AST_BANK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!wr_valid && !$past(rst)) |=> $stable(reg_file)); // R4

  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr >= 8'(NUM_REGS)) |=> $stable(reg_file)); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!wr_valid && !frame_done)); // R9

endmodule

bind twowire_reg_rx twowire_reg_rx_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_valid   (wr_valid),
  .wr_addr    (wr_addr),
  .frame_done (frame_done),
  .reg_file   (reg_file)
);

// File: tb/sim_twowire_reg_rx.sv
`timescale 1ns/1ps
module sim_twowire_reg_rx;

  localparam int NUM_CH   = 8;
  localparam int NUM_REGS = 4 * NUM_CH;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  link_clk = 1'b0;
  logic                  link_dat = 1'b0;
  logic [7:0]            dev_addr = 8'h3C;
  logic                  wr_valid;
  logic [7:0]            wr_addr;
  logic [7:0]            wr_data;
  logic                  frame_done;
  logic [NUM_REGS*8-1:0] reg_file;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  logic [7:0] exp_regs [NUM_REGS];

  // per-frame observation
  int         nv, nd, vpos, dpos;
  logic [7:0] got_addr, got_data;

  always #2 clk = ~clk;

  twowire_reg_rx #(.NUM_CH(NUM_CH)) u0 (
    .clk(clk), .rst(rst), .link_clk(link_clk), .link_dat(link_dat),
    .dev_addr(dev_addr), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_done(frame_done), .reg_file(reg_file)
  );

  function automatic logic [7:0] reset_byte(input int i);
    return (i < NUM_CH || i >= 3 * NUM_CH) ? 8'h80 : 8'h00;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NUM_REGS; i++) exp_regs[i] = reset_byte(i);
  endtask

  task automatic observe(input bit last, input int k);
    if (wr_valid) begin
      nv++;
      if (last) vpos = k;
      got_addr = wr_addr;
      got_data = wr_data;
    end
    if (frame_done) begin
      nd++;
      if (last) dpos = k;
    end
  endtask

  // One link bit; data wiggles while the link clock is low (R1).
  task automatic send_bit(input logic b, input bit last);
    @(negedge clk); link_dat = ~b; observe(1'b0, 0);
    @(negedge clk); link_dat = b;  observe(1'b0, 0);
    @(negedge clk); observe(1'b0, 0);
    link_clk = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk); observe(last, k);
    end
    link_dat = ~b;
    link_clk = 1'b0;
  endtask

  task automatic send_bits(input logic [21:0] bits, input int n);
    for (int i = 0; i < n; i++) send_bit(bits[i], i == 21);
  endtask

  function automatic logic [21:0] pack(input logic [7:0] a, input logic [5:0] s, input logic [7:0] d);
    return {d, s, a}; // bit 0 sent first: address LSB first, then index, then value (R2)
  endfunction

  task automatic check_bank(input string req);
    for (int i = 0; i < NUM_REGS; i++)
      chk(req, $sformatf("reg_file byte %0d", i), int'(reg_file[8*i +: 8]), int'(exp_regs[i]));
  endtask

  task automatic frame(input logic [7:0] a, input logic [5:0] s, input logic [7:0] d);
    bit hit;
    nv = 0; nd = 0; vpos = 0; dpos = 0;
    hit = (a == dev_addr);
    send_bits(pack(a, s, d), 22);
    repeat (2) begin @(negedge clk); observe(1'b0, 0); end
    if (hit) begin
      chk("R3", "strobe count", nv, 1);
      chk("R3", "strobe edge", vpos, 3);
      chk("R3", "wr_addr", int'(got_addr), int'({2'b00, s}));
      chk("R2", "wr_data", int'(got_data), int'(d));
      if (int'(s) < NUM_REGS) exp_regs[s] = d;
    end else begin
      chk("R4", "strobe count on mismatch", nv, 0);
    end
    chk("R5", "done count", nd, 1);
    chk("R5", "done edge", dpos, 3);
    check_bank(hit ? "R7" : "R4");
  endtask

  initial begin
    void'($urandom(32'd20240728));
    model_reset();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 / R8: reset state
    chk("R9", "wr_valid after reset", int'(wr_valid), 0);
    chk("R9", "frame_done after reset", int'(frame_done), 0);
    check_bank("R8");

    // directed corner cases
    frame(8'h3C, 6'd0, 8'h01);   // R2: LSB-first value 0x01 must not read as 0x80
    frame(8'h3C, 6'd31, 8'hA5);  // R7: top of bank
    frame(8'h3C, 6'd32, 8'h77);  // R7: strobe, no bank change
    frame(8'h3C, 6'd63, 8'hFF);  // R7: highest index
    frame(8'hC3, 6'd5, 8'h11);   // R4: bit-reversed-like mismatch
    frame(8'h3C, 6'd9, 8'h80);   // R6: back-to-back after mismatch
    dev_addr = 8'h5A;            // R10
    frame(8'h3C, 6'd1, 8'h22);   // now mismatch
    frame(8'h5A, 6'd1, 8'h33);   // now match

    // R9: reset in the middle of a frame, then a clean frame
    send_bits(pack(8'h5A, 6'd2, 8'h44), 10);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R9", "frame_done after mid-frame reset", int'(frame_done), 0);
    frame(8'h5A, 6'd24, 8'h5C);  // R9: decodes from address field

    // constrained random, back-to-back (R6)
    for (int n = 0; n < 40; n++) begin
      logic [7:0] a;
      a = ($urandom % 2 == 0) ? dev_addr : 8'($urandom);
      frame(a, 6'($urandom % 64), 8'($urandom));
    end

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule